// File: doc/BRIEF.md
# Three-Wire Serial Shift Unit

This block is an 8-bit shift engine for a three-wire link made of a serial clock, a data input and a data output. Software loads the data register with a parallel write. It then runs eight serial clock cycles. In each cycle one bit leaves at the most significant end and one bit enters at the least significant end. Bits travel most significant first.

The serial clock comes from one of two sources:
- **Master:** each write of a toggle strobe bit in the control register inverts the outgoing clock, one edge per write.
- **Slave:** an external clock input is resynchronised and edge-detected.

The edge mode selects which clock edge samples the input and which edge shifts the register. Mode 0 matches SPI data mode 0 and mode 1 matches SPI data mode 1.

A counter advances on every clock edge, so a byte takes 16 edges. When the counter wraps from 15 to 0 it sets a sticky overflow flag. That flag can also drive an interrupt output.

Register access uses three simple write ports and two read buses:

| Register | Bit | Meaning |
|---|---|---|
| Control | 0 | Edge mode |
| Control | 1 | Clock source: 0 = strobe-driven master, 1 = external slave |
| Control | 2 | Toggle strobe (self-clearing, never stored) |
| Control | 3 | Interrupt enable |
| Status | 7 | Overflow flag; write 1 to clear |
| Status | 6 | Write 1 to zero the edge counter |
| Status | 3:0 | Edge counter (read) |

Top module: `ser_shift_unit`

## Requirements
- R1: After reset the data register, edge counter, overflow flag, clock output, data output and interrupt output are all zero.
- R2: A data register write loads all 8 bits in parallel, and do_o shows the new bit 7 from the cycle after the write. The write takes priority over a shift in the same cycle.
- R3: With edge mode 0 (control bit 0 = 0), di_i is captured on the rising clock edge. On the falling edge the register shifts left: the captured bit enters at bit 0 and do_o shows the next bit.
- R4: With edge mode 1 (control bit 0 = 1), the edges are swapped. The register shifts on the rising edge, loading bit 0 from the value captured at the previous falling edge. di_i is captured on the falling edge.
- R5: Every clock edge increments the 4-bit edge counter. On the 16th edge it wraps from 15 to 0 and sets the overflow flag (status bit 7).
- R6: The overflow flag stays set until a status write with bit 7 = 1 clears it. A status write with bit 7 = 0 leaves it unchanged.
- R7: A status write with bit 6 = 1 zeroes the edge counter, taking priority over a coincident edge.
- R8: With control bit 1 = 0, each control write with bit 2 = 1 inverts sck_o and acts as exactly one edge. With control bit 1 = 1, the strobe is ignored: sck_o and the counter do not change.
- R9: With control bit 1 = 1, an edge on sck_ext_i passes a two-flop synchronizer. It acts on the register and counter at the third rising system clock after the input changes, and not earlier.
- R10: irq_o equals the overflow flag while control bit 3 is 1, and is 0 while control bit 3 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dat_we_i | input | 1 | Data register write enable |
| dat_wdata_i | input | 8 | Data register write value |
| ctl_we_i | input | 1 | Control register write enable |
| ctl_wdata_i | input | 8 | Control write value: bit0 edge mode, bit1 external clock, bit2 toggle strobe, bit3 irq enable |
| sts_we_i | input | 1 | Status register write enable |
| sts_wdata_i | input | 8 | Status write value: bit7 clears overflow, bit6 zeroes counter |
| sck_ext_i | input | 1 | External serial clock (slave) |
| di_i | input | 1 | Serial data in |
| sck_o | output | 1 | Generated serial clock (master) |
| do_o | output | 1 | Serial data out, register bit 7 |
| dat_o | output | 8 | Data register read value |
| sts_o | output | 8 | Status read value: bit7 overflow, bits 3:0 edge counter |
| irq_o | output | 1 | Overflow interrupt |

## Verification
A wrong capture or shift edge shows on do_o within one strobe write: the output bit changes on the wrong half-cycle. A stale capture latch shows as a corrupted received byte on dat_o once the eighth cycle ends. A counter that skips or double-counts an edge moves the overflow flag off the 16th edge, and that is visible on sts_o at once. A synchronizer with the wrong depth is caught on the exact cycle where the counter is expected to stay still and then to step.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int CTL_MODE = 0;
  localparam int CTL_EXT  = 1;
  localparam int CTL_TGL  = 2;
  localparam int CTL_IEN  = 3;
  localparam int STS_OVF  = 7;
  localparam int STS_CCLR = 6;

  typedef enum logic {
    MODE_RISE_SAMPLE = 1'b0,
    MODE_FALL_SAMPLE = 1'b1
  } edge_mode_e;

  typedef struct packed {
    logic       irq_en;
    logic       ext_sel;
    edge_mode_e mode;
  } ctl_t;
endpackage

// File: rtl/ssu_clk_src.sv
module ssu_clk_src #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_sel_i,
  input  logic strobe_i,
  input  logic sck_ext_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic                 sck_q;
  logic                 tgl;
  logic                 ext_rise, ext_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q[0] <= 1'b0;
    else         sync_q[0] <= sck_ext_i;
  end

  // synchronizer chain plus one history stage for edge detect
  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign ext_fall = ~sync_q[SYNC_STAGES-1] & sync_q[SYNC_STAGES];

  assign tgl = strobe_i & ~ext_sel_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sck_q <= 1'b0;
    else if (tgl) sck_q <= ~sck_q;
  end

  assign sck_o  = sck_q;
  assign rise_o = ext_sel_i ? ext_rise : (tgl & ~sck_q);
  assign fall_o = ext_sel_i ? ext_fall : (tgl & sck_q);
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              sample_i,
  input  logic              shift_i,
  input  logic              di_i,
  output logic [DATA_W-1:0] data_o,
  output logic              do_o
);
  logic [DATA_W-1:0] data_q;
  logic              cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cap_q <= 1'b0;
    else if (sample_i) cap_q <= di_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_i)  data_q <= load_data_i;
    else if (shift_i) data_q <= {data_q[DATA_W-2:0], cap_q};
  end

  assign data_o = data_q;
  assign do_o   = data_q[DATA_W-1];
endmodule

// File: rtl/ssu_edge_cnt.sv
module ssu_edge_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             clr_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             wrap;

  assign wrap = edge_i & ~clr_i & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (edge_i) cnt_q <= cnt_q + 1'b1;
  end

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (wrap)       flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/ser_shift_unit.sv
module ser_shift_unit #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dat_we_i,
  input  logic [DATA_W-1:0] dat_wdata_i,
  input  logic              ctl_we_i,
  input  logic [7:0]        ctl_wdata_i,
  input  logic              sts_we_i,
  input  logic [7:0]        sts_wdata_i,
  input  logic              sck_ext_i,
  input  logic              di_i,
  output logic              sck_o,
  output logic              do_o,
  output logic [DATA_W-1:0] dat_o,
  output logic [7:0]        sts_o,
  output logic              irq_o
);
  import ssu_pkg::*;

  localparam int CNT_W = $clog2(2 * DATA_W);

  ctl_t             ctl_q;
  logic             ext_sel;
  logic             strobe;
  logic             rise, fall, edge_ev;
  logic             sample_ev, shift_ev;
  logic [CNT_W-1:0] cnt;
  logic             ovf;
  logic             unused_bits;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '{irq_en: 1'b0, ext_sel: 1'b0, mode: MODE_RISE_SAMPLE};
    end else if (ctl_we_i) begin
      ctl_q.irq_en  <= ctl_wdata_i[CTL_IEN];
      ctl_q.ext_sel <= ctl_wdata_i[CTL_EXT];
      ctl_q.mode    <= edge_mode_e'(ctl_wdata_i[CTL_MODE]);
    end
  end

  assign ext_sel = ctl_q.ext_sel;
  assign strobe  = ctl_we_i & ctl_wdata_i[CTL_TGL];

  ssu_clk_src #(.SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_sel_i(ext_sel),
    .strobe_i (strobe),
    .sck_ext_i(sck_ext_i),
    .sck_o    (sck_o),
    .rise_o   (rise),
    .fall_o   (fall)
  );

  assign sample_ev = (ctl_q.mode == MODE_RISE_SAMPLE) ? rise : fall;
  assign shift_ev  = (ctl_q.mode == MODE_RISE_SAMPLE) ? fall : rise;
  assign edge_ev   = rise | fall;

  ssu_shifter #(.DATA_W(DATA_W)) u_shf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (dat_we_i),
    .load_data_i(dat_wdata_i),
    .sample_i   (sample_ev),
    .shift_i    (shift_ev),
    .di_i       (di_i),
    .data_o     (dat_o),
    .do_o       (do_o)
  );

  ssu_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_ev),
    .clr_i     (sts_we_i & sts_wdata_i[STS_CCLR]),
    .flag_clr_i(sts_we_i & sts_wdata_i[STS_OVF]),
    .cnt_o     (cnt),
    .flag_o    (ovf)
  );

  always_comb begin
    sts_o              = '0;
    sts_o[STS_OVF]     = ovf;
    sts_o[CNT_W-1:0]   = cnt;
  end

  assign irq_o = ovf & ctl_q.irq_en;

  assign unused_bits = ^{ctl_wdata_i[7:4], sts_wdata_i[5:0]};
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dat_we_i,
  input logic [DATA_W-1:0] dat_wdata_i,
  input logic              sts_we_i,
  input logic [7:0]        sts_wdata_i,
  input logic              ext_sel_i,
  input logic              sck_o,
  input logic              do_o,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              ovf_i,
  input logic              irq_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_do_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dat_we_i) |-> do_o == $past(dat_wdata_i[DATA_W-1]));

  assert_cnt_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_i) |-> (cnt_i == $past(cnt_i) + 1'b1) || (cnt_i == '0));

  assert_ovf_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_i) |-> ($past(cnt_i) == CNT_MAX) && (cnt_i == '0));

  assert_ovf_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ovf_i) |-> $past(sts_we_i && sts_wdata_i[7]));

  assert_slave_sck_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_sel_i && $past(ext_sel_i)) |-> $stable(sck_o));

  assert_irq_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ovf_i);
endmodule

bind ser_shift_unit ssu_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dat_we_i   (dat_we_i),
  .dat_wdata_i(dat_wdata_i),
  .sts_we_i   (sts_we_i),
  .sts_wdata_i(sts_wdata_i),
  .ext_sel_i  (ext_sel),
  .sck_o      (sck_o),
  .do_o       (do_o),
  .cnt_i      (cnt),
  .ovf_i      (ovf),
  .irq_o      (irq_o)
);

// File: tb/tb_ser_shift_unit.sv
`timescale 1ns/1ps
module tb_ser_shift_unit;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       dat_we_i = 1'b0;
  logic [7:0] dat_wdata_i = '0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       sts_we_i = 1'b0;
  logic [7:0] sts_wdata_i = '0;
  logic       sck_ext_i = 1'b0;
  logic       di_i = 1'b0;
  logic       sck_o, do_o, irq_o;
  logic [7:0] dat_o, sts_o;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic lat_exp = 1'b0;

  always #4 clk = ~clk;

  ser_shift_unit dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .dat_we_i(dat_we_i), .dat_wdata_i(dat_wdata_i),
    .ctl_we_i(ctl_we_i), .ctl_wdata_i(ctl_wdata_i),
    .sts_we_i(sts_we_i), .sts_wdata_i(sts_wdata_i),
    .sck_ext_i(sck_ext_i), .di_i(di_i),
    .sck_o(sck_o), .do_o(do_o), .dat_o(dat_o), .sts_o(sts_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(negedge clk); dat_we_i = 1'b1; dat_wdata_i = v;
    @(negedge clk); dat_we_i = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_we_i = 1'b1; ctl_wdata_i = v;
    @(negedge clk); ctl_we_i = 1'b0;
  endtask

  task automatic wr_sts(input logic [7:0] v);
    @(negedge clk); sts_we_i = 1'b1; sts_wdata_i = v;
    @(negedge clk); sts_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 dat", dat_o, 0);
    check("R1 sts", sts_o, 0);
    check("R1 sck/do/irq", {sck_o, do_o, irq_o}, 0);
  endtask

  task automatic t_master_m0();
    logic [7:0] tx = 8'hA5, rx = 8'h3C;
    wr_ctl(8'h00);
    wr_sts(8'hC0);
    wr_dat(tx);
    check("R2 dat load", dat_o, tx);
    check("R2 do msb", do_o, tx[7]);
    for (int i = 7; i >= 0; i--) begin
      di_i = rx[i];
      wr_ctl(8'h04);
      check("R8 sck rise", sck_o, 1);
      check("R3 do held on rise", do_o, tx[i]);
      wr_ctl(8'h04);
      check("R8 sck fall", sck_o, 0);
      if (i > 0) check("R3 do after fall", do_o, tx[i-1]);
      if (i == 4) check("R5 mid count", sts_o[3:0], 8);
    end
    check("R3 received", dat_o, rx);
    check("R5 wrap", sts_o[3:0], 0);
    check("R5 ovf set", sts_o[7], 1);
    lat_exp = rx[0];
  endtask

  task automatic t_master_m1();
    logic [7:0] tx = 8'h96, rx = 8'h71;
    logic       l0 = lat_exp;
    wr_ctl(8'h01);
    wr_sts(8'hC0);
    check("R6 ovf cleared", sts_o[7], 0);
    wr_dat(tx);
    for (int k = 1; k <= 8; k++) begin
      wr_ctl(8'h05);
      if (k < 8) check("R4 do after rise", do_o, tx[7-k]);
      di_i = rx[8-k];
      wr_ctl(8'h05);
    end
    check("R4 received", dat_o, {l0, rx[7:1]});
    check("R5 ovf mode1", sts_o[7], 1);
    lat_exp = rx[0];
  endtask

  task automatic t_w1c();
    wr_sts(8'h00);
    check("R6 write0 keeps", sts_o[7], 1);
    repeat (3) @(negedge clk);
    check("R6 sticky", sts_o[7], 1);
    wr_sts(8'h80);
    check("R6 write1 clears", sts_o[7], 0);
  endtask

  task automatic t_cnt_clear();
    wr_ctl(8'h00);
    repeat (3) wr_ctl(8'h04);
    check("R5 count3", sts_o[3:0], 3);
    wr_sts(8'h40);
    check("R7 cleared", sts_o[3:0], 0);
    check("R7 ovf untouched", sts_o[7], 0);
    wr_ctl(8'h04);
    check("R7 counts again", sts_o[3:0], 1);
    check("R8 sck back low", sck_o, 0);
    wr_sts(8'h40);
    lat_exp = di_i;
  endtask

  task automatic t_irq();
    wr_ctl(8'h08);
    wr_sts(8'hC0);
    for (int e = 0; e < 15; e++) wr_ctl(8'h0C);
    check("R10 no irq before wrap", irq_o, 0);
    wr_ctl(8'h0C);
    check("R10 irq on ovf", irq_o, 1);
    wr_ctl(8'h00);
    check("R10 irq masked", irq_o, 0);
    check("R10 ovf still set", sts_o[7], 1);
    wr_ctl(8'h08);
    check("R10 irq unmasked", irq_o, 1);
    wr_sts(8'h80);
    check("R10 irq follows clear", irq_o, 0);
    wr_ctl(8'h00);
  endtask

  task automatic t_slave();
    logic [7:0] tx = 8'h5A, rx = 8'hC3;
    wr_ctl(8'h02);
    wr_sts(8'hC0);
    wr_dat(tx);
    wr_ctl(8'h06);
    check("R8 strobe ignored sck", sck_o, 0);
    check("R8 strobe ignored cnt", sts_o[3:0], 0);
    for (int i = 7; i >= 0; i--) begin
      di_i = rx[i];
      @(negedge clk); sck_ext_i = 1'b1;
      if (i == 7) begin
        @(negedge clk);
        @(negedge clk);
        check("R9 not yet", sts_o[3:0], 0);
        @(negedge clk);
        check("R9 third edge", sts_o[3:0], 1);
        repeat (2) @(negedge clk);
      end else begin
        repeat (5) @(negedge clk);
      end
      check("R3 slave do held", do_o, tx[i]);
      sck_ext_i = 1'b0;
      repeat (5) @(negedge clk);
      if (i > 0) check("R3 slave do shift", do_o, tx[i-1]);
    end
    check("R9 slave received", dat_o, rx);
    check("R9 slave ovf", sts_o[7], 1);
    check("R8 sck idle in slave", sck_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_master_m0();
    t_master_m1();
    t_w1c();
    t_cnt_clear();
    t_irq();
    t_slave();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule